// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART serial core and an infrared transceiver. In infrared mode it turns the UART's NRZ transmit stream into short light pulses, one pulse per 0 bit. It also turns pulses from the transceiver back into NRZ receive data for the UART. It runs on the peripheral clock and takes a single-cycle tick at 16 times the baud rate from the UART's baud generator. When infrared mode is off, both directions pass straight through and the UART works as a plain serial port.

A six-bit control word is loaded through a single write/read port. Its fields are:

- an enable bit;
- a receive-polarity bit, which flips the incoming line and leaves the transmit side alone;
- a pulse-mode bit that chooses the transmit pulse width. With the bit clear the width is three ticks, which is 3/16 of a bit. With the bit set the width is 2^(k+1) peripheral clocks, where k is a 3-bit divisor. Software must pick a k that keeps the fixed pulse at or above 1.63 us for the clock in use.

The transmit side is a three-state machine:

- `TX_IDLE`: the line is at mark and no bit is being timed.
- `TX_PULSE`: the output is high.
- `TX_GAP`: the rest of the bit period.

Transitions:

- IDLE to PULSE: launch, on a tick while the UART drives 0.
- PULSE to GAP: width reached.
- PULSE or GAP to PULSE: a bit boundary with the next bit 0.
- PULSE or GAP to IDLE: a bit boundary with the next bit 1.
- Any state to IDLE: whenever the enable bit is clear.

The receive side is a two-state machine:

- `RX_IDLE`: the NRZ output is high.
- `RX_LOW`: the NRZ output is low.

Transitions:

- IDLE to LOW: a rising edge of the synchronised, polarity-corrected input.
- LOW to LOW: a new edge, which restarts the 16-tick count.
- LOW to IDLE: 16 ticks pass without a new edge.
- Any state to IDLE: whenever the enable bit is clear.

Top module: `irda_sir_codec`

## Requirements
- R1: After reset the control word reads as 0, so infrared mode is off and `ir_tx_o` equals `ser_txd_i`.
- R2: A write stores data bits 5:0, laid out as bit 0 enable, bit 1 receive polarity, bit 2 pulse mode (1 = fixed width) and bits 5:3 the divisor k. A read returns those bits with bits 31:6 at 0.
- R3: With enable at 0, `ir_tx_o` follows `ser_txd_i` in the same cycle. `ser_rxd_o` follows the polarity-corrected `ir_rx_i` after two synchronising flops.
- R4: With enable at 1, a 1 bit and the idle line give no pulse, so `ir_tx_o` stays low. Each 0 bit gives exactly one pulse, and consecutive 0 bits give separate pulses.
- R5: A pulse rises in the clock after the tick at which a 0 bit is seen. Bit periods are 16 ticks long and are counted from that tick, and `ser_txd_i` is sampled again at each boundary.
- R6: With pulse mode 0, `ir_tx_o` stays high for exactly three tick intervals.
- R7: With pulse mode 1, `ir_tx_o` stays high for exactly 2^(k+1) clocks for every k from 0 to 7.
- R8: The receive-polarity bit leaves the transmit pulse count, timing and widths unchanged.
- R9: With enable at 1, a rising edge of the corrected, synchronised input drives `ser_rxd_o` low. The output returns high after 16 ticks with no further edge, and with no pulses it stays high.
- R10: With the polarity bit at 1, the receive input is inverted before detection, so a low-going pulse on `ir_rx_i` is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | peripheral clock |
| rst_n | input | 1 | active-low asynchronous reset |
| baud_tick16 | input | 1 | one-cycle strobe at 16x the baud rate |
| cfg_wr | input | 1 | control word write strobe |
| cfg_wdata | input | 32 | control write data |
| cfg_rdata | output | 32 | control word read data |
| ser_txd_i | input | 1 | NRZ transmit data from the UART |
| ser_rxd_o | output | 1 | NRZ receive data to the UART |
| ir_tx_o | output | 1 | pulse output to the transceiver |
| ir_rx_i | input | 1 | pulse input from the transceiver |

## Verification
The hardest situation to reach from the ports is a run of 0 bits. In that case the transmit machine must leave PULSE or GAP and re-enter PULSE at a bit boundary, and the launch tick must line up with the driven data. The bench generates the tick itself and places every data bit on a known tick edge. It then drives all-zero bytes and random bytes under every divisor and records each pulse's start phase and width. On receive, changing the polarity while pulses are enabled would create a false edge. The bench therefore changes polarity only while the codec is disabled, then enables it and checks that the idle line stays high before any pulses are sent.

// File: rtl/irda_pkg.sv
package irda_pkg;

    localparam int DIV_W     = 3;
    localparam int CTRL_W    = DIV_W + 3;
    localparam int FIX_CNT_W = 1 << DIV_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             fix;
        logic             inv;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_LOW  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/irda_cfg_reg.sv
module irda_cfg_reg
    import irda_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output ctrl_t            ctrl_o,
    output logic [REG_W-1:0] rdata_o
);

    ctrl_t ctrl_q;
    logic  unused_wr_hi;

    assign unused_wr_hi = ^wdata_i[REG_W-1:CTRL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    assign ctrl_o  = ctrl_q;
    assign rdata_o = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> rdata_o[CTRL_W-1:0] == $past(wdata_i[CTRL_W-1:0])); // R2

endmodule

// File: rtl/irda_tx_shaper.sv
module irda_tx_shaper
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  txd_i,
    input  ctrl_t ctrl_i,
    output logic  pulse_o
);

    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    tx_state_e            state_q, state_d;
    logic [TW-1:0]        tcnt_q;
    logic [PW-1:0]        pcnt_q;
    logic [FIX_CNT_W-1:0] fcnt_q;
    logic [FIX_CNT_W-1:0] fix_load;
    logic                 bit_end;
    logic                 launch;
    logic                 pulse_done;
    logic                 restart;

    // width minus one for 2^(k+1) clocks: all ones shifted right by (max-k)
    assign fix_load   = {FIX_CNT_W{1'b1}} >> (~ctrl_i.div);
    assign bit_end    = tick_i && (tcnt_q == TW'(TICKS_PER_BIT - 1));
    assign launch     = tick_i && !txd_i;
    assign pulse_done = ctrl_i.fix ? (fcnt_q == '0)
                                   : (tick_i && (pcnt_q == PW'(PULSE_TICKS - 1)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!ctrl_i.en) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (launch) state_d = TX_PULSE;
                end
                TX_PULSE: begin
                    if (bit_end)         state_d = txd_i ? TX_IDLE : TX_PULSE;
                    else if (pulse_done) state_d = TX_GAP;
                end
                TX_GAP: begin
                    if (bit_end) state_d = txd_i ? TX_IDLE : TX_PULSE;
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    assign restart = (state_d == TX_PULSE) && ((state_q == TX_IDLE) || bit_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // bit-period, tick-width and clock-width counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            pcnt_q <= '0;
            fcnt_q <= '0;
        end else if (restart) begin
            tcnt_q <= '0;
            pcnt_q <= '0;
            fcnt_q <= fix_load;
        end else begin
            if (tick_i && (state_q != TX_IDLE)) tcnt_q <= tcnt_q + 1'b1;
            if (state_q == TX_PULSE) begin
                if (tick_i)        pcnt_q <= pcnt_q + 1'b1;
                if (fcnt_q != '0)  fcnt_q <= fcnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pulse_o = (state_q == TX_PULSE);
    end

    // checker counters
    logic [31:0] hi_run_q;
    logic [31:0] tick_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q   <= '0;
            tick_run_q <= '0;
        end else if (!pulse_o || bit_end) begin
            hi_run_q   <= '0;
            tick_run_q <= '0;
        end else begin
            hi_run_q <= hi_run_q + 1'b1;
            if (tick_i) tick_run_q <= tick_run_q + 1'b1;
        end
    end

    AST_TX_LAUNCH_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(tick_i && !txd_i)); // R5

    AST_TX_FIXED_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.fix && pulse_o) |-> (hi_run_q < (32'd2 << ctrl_i.div))); // R7

    AST_TX_TICK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.fix && pulse_o) |-> (tick_run_q < 32'(PULSE_TICKS))); // R6

    AST_TX_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.en |=> !pulse_o); // R3

endmodule

// File: rtl/irda_rx_stretcher.sv
module irda_rx_stretcher
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  logic  rx_i,
    input  ctrl_t ctrl_i,
    output logic  rxd_o
);

    localparam int TW = $clog2(TICKS_PER_BIT);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_fixed;
    logic                   rx_s;
    logic                   prev_q;
    logic                   rise;
    rx_state_e              state_q, state_d;
    logic [TW-1:0]          rcnt_q;

    assign rx_fixed = rx_i ^ ctrl_i.inv;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= rx_fixed;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign rx_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= rx_s;
    end

    assign rise = rx_s && !prev_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!ctrl_i.en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (rise) state_d = RX_LOW;
                end
                RX_LOW: begin
                    if (rise)                                              state_d = RX_LOW;
                    else if (tick_i && (rcnt_q == TW'(TICKS_PER_BIT - 1))) state_d = RX_IDLE;
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            rcnt_q <= '0;
        else if (rise)                         rcnt_q <= '0;
        else if (state_q == RX_LOW && tick_i)  rcnt_q <= rcnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        rxd_o = ctrl_i.en ? (state_q != RX_LOW) : rx_s;
    end

    AST_RX_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.en && rise) ##1 ctrl_i.en |-> !rxd_o); // R9

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
    import irda_pkg::*;
#(
    parameter int REG_W         = 32,
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick16,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             ser_txd_i,
    output logic             ser_rxd_o,
    output logic             ir_tx_o,
    input  logic             ir_rx_i
);

    ctrl_t ctrl;
    logic  tx_pulse;

    irda_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .wdata_i (cfg_wdata),
        .ctrl_o  (ctrl),
        .rdata_o (cfg_rdata)
    );

    irda_tx_shaper #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .PULSE_TICKS   (PULSE_TICKS)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (baud_tick16),
        .txd_i   (ser_txd_i),
        .ctrl_i  (ctrl),
        .pulse_o (tx_pulse)
    );

    irda_rx_stretcher #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (baud_tick16),
        .rx_i   (ir_rx_i),
        .ctrl_i (ctrl),
        .rxd_o  (ser_rxd_o)
    );

    always_comb begin
        ir_tx_o = ctrl.en ? tx_pulse : ser_txd_i;
    end

endmodule

// File: tb/sim_irda_sir_codec.sv
module sim_irda_sir_codec;

    localparam int TP     = 20;
    localparam int TPB    = 16;
    localparam int BITCLK = TP * TPB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txd = 1'b1;
    logic        rxd;
    logic        ir_tx;
    logic        ir_rx = 1'b0;

    int checks = 0;
    int fails  = 0;
    int ph     = 0;
    int cyc    = 0;
    int run    = 0;
    int np     = 0;
    int pw_arr   [0:63];
    int pph_arr  [0:63];
    int pcyc_arr [0:63];

    always #10 clk = ~clk;

    irda_sir_codec u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick16 (tick),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .ser_txd_i   (txd),
        .ser_rxd_o   (rxd),
        .ir_tx_o     (ir_tx),
        .ir_rx_i     (ir_rx)
    );

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (ir_tx === 1'b1) begin
            if (run == 0 && np < 64) begin
                pph_arr[np]  = ph;
                pcyc_arr[np] = cyc;
            end
            run++;
        end else if (run > 0) begin
            if (np < 64) pw_arr[np] = run;
            np++;
            run = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ph   = (ph + 1) % TP;
        tick = (ph == 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    function automatic logic [31:0] mk(input bit en, input bit inv, input bit fix, input int div);
        return {26'b0, 3'(div), fix, inv, en};
    endfunction

    function automatic int exp_width(input bit fix, input int div);
        return fix ? (2 << div) : 3 * TP;
    endfunction

    function automatic int zeros_in(input logic [9:0] f);
        int z = 0;
        for (int i = 0; i < 10; i++) if (!f[i]) z++;
        return z;
    endfunction

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic tx_case(input bit inv, input bit fix, input int div, input logic [7:0] data,
                           input string tag);
        logic [9:0] frame;
        int         zc;
        int         ew;
        frame = {1'b1, data, 1'b0};
        txd   = 1'b1;
        wr_cfg(mk(1'b1, inv, fix, div));
        steps(BITCLK);
        np = 0;
        while (tick !== 1'b1) step();
        for (int b = 0; b < 10; b++) begin
            txd = frame[b];
            steps(BITCLK);
        end
        txd = 1'b1;
        steps(BITCLK);
        zc = zeros_in(frame);
        ew = exp_width(fix, div);
        check(np == zc, {tag, " R4 pulse count"}, np, zc);
        for (int i = 0; i < np && i < 64; i++) begin
            check(pw_arr[i] == ew, {tag, fix ? " R7 fixed width" : " R6 tick width"}, pw_arr[i], ew);
            check(pph_arr[i] == 1, {tag, " R5 launch phase"}, pph_arr[i], 1);
            check(((pcyc_arr[i] - pcyc_arr[0]) % BITCLK) == 0, {tag, " R5 bit spacing"},
                  (pcyc_arr[i] - pcyc_arr[0]) % BITCLK, 0);
        end
    endtask

    task automatic rx_frame(input bit inv, input logic [7:0] data);
        logic [9:0] frame;
        int         pw;
        frame = {1'b1, data, 1'b0};
        for (int b = 0; b < 10; b++) begin
            pw = 2 + int'($urandom % 39);
            if (!frame[b]) begin
                ir_rx = ~inv;
                steps(pw);
                ir_rx = inv;
                steps(8 * TP - pw);
            end else begin
                steps(8 * TP);
            end
            @(negedge clk);
            check(rxd == frame[b], inv ? "R10 inverted decode" : "R9 decode mid-bit",
                  int'(rxd), int'(frame[b]));
            steps(8 * TP);
        end
        steps(2 * BITCLK);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  d;
        int          w_plain [0:63];
        int          n_plain;
        void'($urandom(32'h1DA5EED));

        steps(5);
        rst_n = 1'b1;
        steps(2);

        // R1: reset state
        @(negedge clk);
        check(cfg_rdata == 32'h0, "R1 reset rdata", int'(cfg_rdata), 0);
        txd = 1'b0; step(); @(negedge clk);
        check(ir_tx == 1'b0, "R1 reset passthrough low", int'(ir_tx), 0);
        txd = 1'b1; step(); @(negedge clk);
        check(ir_tx == 1'b1, "R1 reset passthrough high", int'(ir_tx), 1);

        // R2: register layout
        for (int i = 0; i < 8; i++) begin
            v = $urandom;
            wr_cfg(v);
            @(negedge clk);
            check(cfg_rdata == {26'b0, v[5:0]}, "R2 readback", int'(cfg_rdata), int'({26'b0, v[5:0]}));
        end
        wr_cfg(32'h0);
        steps(BITCLK);

        // R3: disabled paths, R10 polarity
        ir_rx = 1'b1; steps(4); @(negedge clk);
        check(rxd == 1'b1, "R3 rx passthrough", int'(rxd), 1);
        wr_cfg(mk(1'b0, 1'b1, 1'b0, 0)); steps(4); @(negedge clk);
        check(rxd == 1'b0, "R10 rx passthrough inverted", int'(rxd), 0);
        txd = 1'b0; step(); @(negedge clk);
        check(ir_tx == 1'b0, "R3 tx passthrough", int'(ir_tx), 0);
        txd = 1'b1; ir_rx = 1'b0;
        wr_cfg(32'h0); steps(4);

        // R6, R7: directed widths
        tx_case(1'b0, 1'b0, 0, 8'h00, "316 zeros");
        for (int k = 0; k < 8; k++) tx_case(1'b0, 1'b1, k, 8'hA5, "fixed");
        tx_case(1'b0, 1'b1, 0, 8'hFF, "fixed ones");

        // R8: polarity bit leaves tx untouched
        tx_case(1'b0, 1'b1, 3, 8'h3C, "plain");
        n_plain = np;
        for (int i = 0; i < 64; i++) w_plain[i] = pw_arr[i];
        tx_case(1'b1, 1'b1, 3, 8'h3C, "inv set");
        check(np == n_plain, "R8 count with polarity bit", np, n_plain);
        for (int i = 0; i < np && i < 64; i++)
            check(pw_arr[i] == w_plain[i], "R8 width with polarity bit", pw_arr[i], w_plain[i]);

        // random transmit configurations
        for (int i = 0; i < 6; i++) begin
            d = 8'($urandom);
            tx_case(1'($urandom), 1'($urandom), int'($urandom % 8), d, "random");
        end
        txd = 1'b1;

        // R9: receive stretcher
        wr_cfg(32'h0);
        ir_rx = 1'b0; steps(10);
        wr_cfg(mk(1'b1, 1'b0, 1'b0, 0));
        steps(BITCLK); @(negedge clk);
        check(rxd == 1'b1, "R9 idle high", int'(rxd), 1);
        ir_rx = 1'b1; steps(6); ir_rx = 1'b0;
        steps(15 * TP - 6); @(negedge clk);
        check(rxd == 1'b0, "R9 held low", int'(rxd), 0);
        steps(2 * TP); @(negedge clk);
        check(rxd == 1'b1, "R9 released", int'(rxd), 1);
        steps(BITCLK);
        rx_frame(1'b0, 8'h00);
        for (int i = 0; i < 3; i++) rx_frame(1'b0, 8'($urandom));

        // R10: inverted receive
        wr_cfg(mk(1'b0, 1'b1, 1'b0, 0));
        ir_rx = 1'b1; steps(10);
        wr_cfg(mk(1'b1, 1'b1, 1'b0, 0));
        steps(BITCLK); @(negedge clk);
        check(rxd == 1'b1, "R10 inverted idle high", int'(rxd), 1);
        for (int i = 0; i < 2; i++) rx_frame(1'b1, 8'($urandom));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule